// File: doc/BRIEF.md
# Double-Ranked Crosspoint Switch Controller

This block is a synchronous model of a crosspoint switch with 33 data inputs and 17 data outputs, together with its parallel configuration port. Every output owns a 7-bit route word: the low 6 bits select an input and the top bit enables the output. The route word is held twice. A staging rank accepts writes one output at a time. An active rank copies the whole staging rank in a single clock and drives the selection matrix.

Because of the two ranks, software can stage any number of new routes while traffic keeps flowing on the old ones, and then switch all of them on one update strobe. Staged words can be read back through the same address bus. All control inputs are active-low and are sampled on the rising clock edge. Write, read and update take effect only while the port select is low. The reset input is asynchronous and clears both ranks.

The route data is configuration, not a stream, so the port has no valid/ready handshake. The data path is combinational from `sw_in` to `sw_out`. In place of a high-impedance state, each output has its own `sw_out_vld` flag.

Top module: `xps_top`

## Requirements
- R1: While `rst_n` is low, and after it returns high, every route word in both ranks is zero. `sw_out` and `sw_out_vld` are all 0, and `cfg_rdata` is 0.
- R2: A clock edge with `cfg_sel_n`=0, `cfg_wr_n`=0 and `cfg_rd_n`=1 loads `cfg_wdata` into the staging word of output `cfg_addr`. Bit 6 of the word is the output enable and bits 5:0 are the input select code, with bit 5 the most significant.
- R3: An edge with `cfg_sel_n`=0 and `cfg_rd_n`=0 puts the staging word of `cfg_addr` on `cfg_rdata` after that edge. For an address of 17 or above, 0 is returned. A write strobed in the same cycle is dropped. `cfg_rdata` holds its value between reads.
- R4: Writes to the staging rank leave `sw_out` and `sw_out_vld` unchanged until an update.
- R5: An edge with `cfg_sel_n`=0 and `cfg_upd_n`=0 copies all 17 staging words into the active rank at once. If a write falls in the same cycle, the copy takes the staging value from before that write.
- R6: While `cfg_sel_n`=1, write, read and update strobes have no effect.
- R7: An enabled output whose select code is 0 to 32 drives `sw_in` bit [code] combinationally, with `sw_out_vld`=1.
- R8: A disabled output drives 0, with `sw_out_vld`=0.
- R9: An enabled output whose select code is 33 to 63 drives 0, with `sw_out_vld`=1.
- R10: Writes to addresses 17 to 31 change no stored word.
- R11: Pulling `rst_n` low between clock edges zeroes the outputs at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_sel_n | input | 1 | Port select, active low |
| cfg_wr_n | input | 1 | Staging write strobe, active low |
| cfg_rd_n | input | 1 | Staging readback strobe, active low |
| cfg_upd_n | input | 1 | Staging-to-active transfer strobe, active low |
| cfg_addr | input | 5 | Output index |
| cfg_wdata | input | 7 | Route word {enable, select[5:0]} |
| cfg_rdata | output | 7 | Readback word |
| sw_in | input | 33 | Switch data inputs |
| sw_out | output | 17 | Switch data outputs |
| sw_out_vld | output | 17 | Per-output enable flag |

## Verification
The bench strobes write together with update in one cycle. It then judges the result by the outputs after that edge, which must reflect the old staging word, and after a second update, which must show the new one. It also strobes read together with write in one cycle. A readback of the old word, plus an unchanged word on a later read, shows that the read won. A sweep over every output and every select code stages a word and checks that the outputs stay put before the update. It then checks them after the update with two complementary input patterns.

// File: rtl/xps_pkg.sv
package xps_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2
  } cfg_op_e;

  // read wins over write; nothing happens without the port select
  function automatic cfg_op_e decode_op(input logic sel, input logic wr, input logic rd);
    if (!sel)     return OP_IDLE;
    else if (rd)  return OP_READ;
    else if (wr)  return OP_WRITE;
    else          return OP_IDLE;
  endfunction
endpackage

// File: rtl/xps_stage_rank.sv
module xps_stage_rank
  import xps_pkg::*;
#(
  parameter int N_OUT  = 17,
  parameter int ADDR_W = 5,
  parameter int WORD_W = 7
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  cfg_op_e                       op,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [WORD_W-1:0]             wdata,
  output logic [N_OUT-1:0][WORD_W-1:0]  stage_q,
  output logic [WORD_W-1:0]             rdata
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(N_OUT - 1);

  logic in_range;
  assign in_range = (addr <= LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      rdata   <= '0;
    end else begin
      case (op)
        OP_WRITE: if (in_range) stage_q[addr] <= wdata;
        OP_READ:  rdata <= in_range ? stage_q[addr] : '0;
        default:  ;
      endcase
    end
  end

  // R2: addressed word takes the written data
  a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_WRITE && in_range) |=> stage_q[$past(addr)] == $past(wdata));
  // R3, R6, R10 (non-write operations never touch the rank)
  a_r3_read_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
    (op != OP_WRITE) |=> $stable(stage_q));
  // R10: out-of-range writes leave the rank alone
  a_r10_oob_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_WRITE && !in_range) |=> $stable(stage_q));
  // R3: readback one cycle later
  a_r3_read_data: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_READ && in_range) |=> rdata == $past(stage_q[addr]));
endmodule

// File: rtl/xps_active_rank.sv
module xps_active_rank #(
  parameter int N_OUT  = 17,
  parameter int WORD_W = 7
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          upd,
  input  logic [N_OUT-1:0][WORD_W-1:0]  stage_i,
  output logic [N_OUT-1:0][WORD_W-1:0]  active_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   active_q <= '0;
    else if (upd) active_q <= stage_i;
  end

  // R5: whole rank copied from the pre-edge staging contents
  a_r5_copy: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> active_q == $past(stage_i));
  // R4: no update, no change
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(active_q));
endmodule

// File: rtl/xps_matrix.sv
module xps_matrix #(
  parameter int N_IN   = 33,
  parameter int N_OUT  = 17,
  parameter int SEL_W  = 6,
  parameter int WORD_W = 7
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [N_IN-1:0]               din,
  input  logic [N_OUT-1:0][WORD_W-1:0]  route,
  output logic [N_OUT-1:0]              dout,
  output logic [N_OUT-1:0]              vld
);
  localparam int SPAN = 1 << SEL_W;

  // padding zeros make codes past the last input select a 0
  logic [SPAN-1:0] din_x;
  assign din_x = SPAN'(din);

  for (genvar g = 0; g < N_OUT; g++) begin : g_col
    logic             en;
    logic [SEL_W-1:0] sel;
    assign en      = route[g][WORD_W-1];
    assign sel     = route[g][SEL_W-1:0];
    assign vld[g]  = en;
    assign dout[g] = en & din_x[sel];

    // R8: a disabled column stays quiet
    a_r8_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !vld[g] |-> !dout[g]);
  end
endmodule

// File: rtl/xps_top.sv
module xps_top
  import xps_pkg::*;
#(
  parameter int N_IN  = 33,
  parameter int N_OUT = 17
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               cfg_sel_n,
  input  logic                               cfg_wr_n,
  input  logic                               cfg_rd_n,
  input  logic                               cfg_upd_n,
  input  logic [$clog2(N_OUT)-1:0]           cfg_addr,
  input  logic [$clog2(N_IN):0]              cfg_wdata,
  output logic [$clog2(N_IN):0]              cfg_rdata,
  input  logic [N_IN-1:0]                    sw_in,
  output logic [N_OUT-1:0]                   sw_out,
  output logic [N_OUT-1:0]                   sw_out_vld
);
  localparam int SEL_W  = $clog2(N_IN);
  localparam int WORD_W = SEL_W + 1;
  localparam int ADDR_W = $clog2(N_OUT);

  cfg_op_e op;
  logic    upd;
  logic [N_OUT-1:0][WORD_W-1:0] stage_q;
  logic [N_OUT-1:0][WORD_W-1:0] active_q;

  assign op  = decode_op(!cfg_sel_n, !cfg_wr_n, !cfg_rd_n);
  assign upd = !cfg_sel_n && !cfg_upd_n;

  xps_stage_rank #(.N_OUT(N_OUT), .ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_stage (
    .clk(clk), .rst_n(rst_n), .op(op), .addr(cfg_addr), .wdata(cfg_wdata),
    .stage_q(stage_q), .rdata(cfg_rdata)
  );

  xps_active_rank #(.N_OUT(N_OUT), .WORD_W(WORD_W)) u_active (
    .clk(clk), .rst_n(rst_n), .upd(upd), .stage_i(stage_q), .active_q(active_q)
  );

  xps_matrix #(.N_IN(N_IN), .N_OUT(N_OUT), .SEL_W(SEL_W), .WORD_W(WORD_W)) u_matrix (
    .clk(clk), .rst_n(rst_n), .din(sw_in), .route(active_q),
    .dout(sw_out), .vld(sw_out_vld)
  );

  // R6: deselected port keeps readback stable
  a_r6_desel_rdata: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_sel_n |=> $stable(cfg_rdata));
endmodule

// File: tb/xps_top_bench.sv
module xps_top_bench;
  localparam int NI = 33;
  localparam int NO = 17;

  logic clk = 0;
  logic rst_n = 0;
  logic sel_n = 1, wr_n = 1, rd_n = 1, upd_n = 1;
  logic [4:0] addr = '0;
  logic [6:0] wdata = '0;
  logic [6:0] rdata;
  logic [NI-1:0] sw_in = '0;
  logic [NO-1:0] sw_out, sw_vld;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [6:0] m_stage [NO];
  logic [6:0] m_active[NO];
  logic [6:0] m_rdata;

  always #5 clk = ~clk;

  xps_top u_xps_top (
    .clk(clk), .rst_n(rst_n), .cfg_sel_n(sel_n), .cfg_wr_n(wr_n),
    .cfg_rd_n(rd_n), .cfg_upd_n(upd_n), .cfg_addr(addr), .cfg_wdata(wdata),
    .cfg_rdata(rdata), .sw_in(sw_in), .sw_out(sw_out), .sw_out_vld(sw_vld)
  );

  task automatic model_clear();
    for (int i = 0; i < NO; i++) begin m_stage[i] = '0; m_active[i] = '0; end
    m_rdata = '0;
  endtask

  task automatic check_all(input string req);
    logic [NO-1:0] ed, ev;
    for (int i = 0; i < NO; i++) begin
      int s;
      s = int'(m_active[i][5:0]);
      ev[i] = m_active[i][6];
      ed[i] = m_active[i][6] && (s < NI) ? sw_in[s] : 1'b0;
    end
    checks++;
    if (sw_out !== ed || sw_vld !== ev || rdata !== m_rdata) begin
      errors++;
      $display("FAIL %s: out=%h vld=%h rdata=%h expected out=%h vld=%h rdata=%h",
               req, sw_out, sw_vld, rdata, ed, ev, m_rdata);
    end
  endtask

  // one clocked operation; model follows the requirements
  task automatic cyc(input bit s, input bit w, input bit r, input bit u,
                     input logic [4:0] a, input logic [6:0] d);
    logic [6:0] old_stage[NO];
    @(negedge clk);
    sel_n = !s; wr_n = !w; rd_n = !r; upd_n = !u; addr = a; wdata = d;
    @(posedge clk);
    #2;
    for (int i = 0; i < NO; i++) old_stage[i] = m_stage[i];
    if (s) begin
      if (r) m_rdata = (a < NO) ? m_stage[a] : '0;
      else if (w && a < NO) m_stage[a] = d;
      if (u) for (int i = 0; i < NO; i++) m_active[i] = old_stage[i];
    end
    sel_n = 1; wr_n = 1; rd_n = 1; upd_n = 1;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    model_clear();
    #23;
    check_all("R1 in reset");
    rst_n = 1;
    for (int o = 0; o < NO; o++) begin
      cyc(1, 0, 1, 0, 5'(o), '0);
      check_all("R1 readback zero");
    end

    // sweep every output and every select code
    for (int o = 0; o < NO; o++) begin
      for (int c = 0; c < 64; c++) begin
        logic en;
        en = (c % 5) != 4;
        cyc(1, 1, 0, 0, 5'(o), {en, 6'(c)});
        check_all("R4 staged not active");
        cyc(1, 0, 0, 1, '0, '0);
        sw_in = (c < NI) ? (NI'(1) << c) : '0;
        #1 check_all(!en ? "R8 disabled" : (c < NI ? "R7 forward" : "R9 code out of range"));
        sw_in = ~sw_in;
        #1 check_all(!en ? "R8 disabled" : (c < NI ? "R7 forward inverse" : "R9 code out of range"));
      end
    end

    // readback of all staged words
    for (int o = 0; o < NO; o++) begin
      cyc(1, 0, 1, 0, 5'(o), '0);
      check_all("R3 readback");
    end
    cyc(1, 0, 1, 0, 5'd20, '0);
    check_all("R3 readback out of range");

    // R10: writes above the last output
    for (int a = NO; a < 32; a++) begin
      cyc(1, 1, 0, 0, 5'(a), 7'h55);
      cyc(1, 0, 0, 1, '0, '0);
      check_all("R10 oob write");
    end
    for (int o = 0; o < NO; o++) begin
      cyc(1, 0, 1, 0, 5'(o), '0);
      check_all("R10 readback after oob");
    end

    // R6: deselected strobes
    cyc(0, 1, 0, 0, 5'd3, 7'h41);
    cyc(0, 0, 1, 1, 5'd3, '0);
    check_all("R6 deselected");
    cyc(1, 0, 1, 0, 5'd3, '0);
    check_all("R6 word kept");

    // R3: read and write together
    sw_in = 33'h1_2345_6789;
    cyc(1, 1, 1, 0, 5'd5, 7'h42);
    check_all("R3 read wins");
    cyc(1, 0, 1, 0, 5'd5, '0);
    check_all("R3 write dropped");

    // R5: write and update together
    cyc(1, 1, 0, 1, 5'd7, 7'h40);
    check_all("R5 update takes old word");
    cyc(1, 0, 0, 1, '0, '0);
    check_all("R5 new word after second update");

    // R11: asynchronous reset between edges
    @(negedge clk);
    #2 rst_n = 0;
    #1;
    model_clear();
    check_all("R11 async reset");
    @(negedge clk);
    rst_n = 1;
    cyc(1, 0, 1, 0, 5'd7, '0);
    check_all("R1 cleared after reset");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule